// File: doc/BRIEF.md
# Selectable-Format PCM Serial Port

This block moves one audio sample per frame between a host and an internal audio path. It uses a bit clock and a frame sync, with one receive lane and one transmit lane. Both lanes run in the system clock domain. The block finds the rising edges of the bit clock by comparing the sampled line with its value one cycle earlier, and it shifts data on those edges only.

Each sample is either an 8-bit mu-law code or a 16-bit linear two's complement word. The frame sync is either normal style, held high for the whole sample, or short style, a pulse one bit clock long. A received mu-law code is expanded to linear. The received sample, once linear, is added with saturation to the internal stream `int_in`. The outgoing linear sample `int_tx` is compressed to mu-law when that format is active.

The format and sync selections are captured only while reset is active. Reset comes from the asynchronous pin or from the synchronous soft-reset request. The transmit lane reports through `tx_oe` whether the pad should drive.

Top module: `pcm_serial_port`

## Requirements
- R1: `tx_oe` is 0 under either reset, from reset release until the first frame's first data bit, between frames, and during any frame whose data bits see `tx_en` low.
- R2: The active format is mu-law when (`fmt_pin` OR `fmt_reg`) is 1 at reset, and 16-bit linear when it is 0. Short-frame sync is active when `sync_sel` is 1 at reset, and normal sync when it is 0.
- R3: Changes on `fmt_pin`, `fmt_reg` or `sync_sel` while no reset is active have no effect until the next reset.
- R4: With normal sync, a frame starts on the bit-clock rising edge that first sees `fsync` high. That same edge samples the MSB of `rx_data` and drives the MSB on `tx_data`, and the following edges carry the remaining bits MSB first.
- R5: With short-frame sync, the edge that sees the sync rise carries no data and keeps `tx_oe` low. The MSB is on the next rising edge.
- R6: A received mu-law code is expanded per G.711: the code is inverted, bit 7 is the sign (1 after inversion means negative), bits 6:4 are the segment and bits 3:0 the mantissa, and the magnitude is ((mantissa*8+132) shifted left by segment) - 132. Code 0xFF expands to 0.
- R7: In linear mode the 16 received bits are taken as a two's complement sample, MSB first.
- R8: One clock after the edge of the last data bit, `mix_valid` pulses for one cycle and `mix_out` holds `int_in` plus the received linear sample, saturated to -32768..+32767.
- R9: The transmit word is taken from `int_tx` on the frame-start edge. In mu-law mode it is sent as the G.711 code: clip the magnitude to 32635, add 132, find the segment from the highest set bit, and invert {sign, segment, mantissa}. In linear mode it is sent unchanged.
- R10: An idle receive line, all ones in mu-law or all zeros in linear, gives `mix_out` equal to `int_in`.
- R11: `tx_oe` falls on the first bit-clock rising edge after the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous reset request from a control register |
| fmt_pin | input | 1 | Format select pin (1 = mu-law) |
| fmt_reg | input | 1 | Format select register bit, ORed with the pin |
| sync_sel | input | 1 | 0 = normal sync, 1 = short-frame sync |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| rx_data | input | 1 | Serial receive data |
| tx_en | input | 1 | Transmit enable |
| int_in | input | 16 | Internal linear stream to mix with |
| int_tx | input | 16 | Internal linear sample to transmit |
| mix_out | output | 16 | Saturated sum of received sample and `int_in` |
| mix_valid | output | 1 | One-cycle pulse when `mix_out` updates |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable (0 = high impedance) |

## Verification
The hardest situation to reach from the ports is a configuration change that must be ignored. Pin and register values only count when they are present during reset, so the bench changes `fmt_pin` in the middle of operation and runs a full linear frame. Only after that does it pulse the soft reset and check that the next frame is mu-law. Saturation in both directions needs operand pairs at the extremes of both formats, so directed frames with 0x7FFF, 0x8000 and the largest mu-law codes are mixed in with random words and random internal samples.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam int LIN_W = 16;
  localparam int MU_W  = 8;
  localparam logic [LIN_W-1:0] MU_BIAS = 16'h0084;
  localparam logic [LIN_W-1:0] MU_CLIP = 16'd32635;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ARM  = 2'd1,
    FR_DATA = 2'd2
  } frame_st_e;

  // G.711 mu-law compression of a 16-bit two's complement sample
  function automatic logic [MU_W-1:0] mulaw_encode(input logic [LIN_W-1:0] smp);
    logic             neg;
    logic [LIN_W-1:0] mag;
    logic [LIN_W-1:0] shifted;
    logic [2:0]       seg;
    neg = smp[LIN_W-1];
    mag = neg ? (~smp + 16'd1) : smp;
    if (mag > MU_CLIP) mag = MU_CLIP;
    mag = mag + MU_BIAS;
    seg = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (mag[7+i]) seg = 3'(i);
    end
    shifted = mag >> (32'(seg) + 32'd3);
    return ~{neg, seg, shifted[3:0]};
  endfunction

  // G.711 mu-law expansion to a 16-bit two's complement sample
  function automatic logic [LIN_W-1:0] mulaw_decode(input logic [MU_W-1:0] code);
    logic [MU_W-1:0]  c;
    logic [LIN_W-1:0] t;
    c = ~code;
    t = (16'(c[3:0]) << 3) + MU_BIAS;
    t = t << c[6:4];
    return c[7] ? (MU_BIAS - t) : (t - MU_BIAS);
  endfunction

  function automatic logic [LIN_W-1:0] sat_add(input logic [LIN_W-1:0] a,
                                               input logic [LIN_W-1:0] b);
    logic [LIN_W:0] sum;
    sum = {a[LIN_W-1], a} + {b[LIN_W-1], b};
    if (sum[LIN_W] != sum[LIN_W-1])
      return sum[LIN_W] ? {1'b1, {(LIN_W-1){1'b0}}} : {1'b0, {(LIN_W-1){1'b1}}};
    return sum[LIN_W-1:0];
  endfunction

endpackage

// File: rtl/pcm_reset_cfg.sv
module pcm_reset_cfg #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic fmt_pin,
  input  logic fmt_reg,
  input  logic sync_sel,
  output logic arst_n,
  output logic hold,
  output logic cfg_mulaw,
  output logic cfg_short
);

  logic [STAGES-1:0] rsync_q;
  logic              mu_d, mu_q, sh_d, sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[STAGES-2:0], 1'b1};
  end

  assign arst_n = rsync_q[STAGES-1];
  assign hold   = !arst_n || soft_rst;

  always_comb begin
    mu_d = mu_q;
    sh_d = sh_q;
    if (hold) begin
      mu_d = fmt_pin | fmt_reg;
      sh_d = sync_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mu_q <= 1'b0;
      sh_q <= 1'b0;
    end else begin
      mu_q <= mu_d;
      sh_q <= sh_d;
    end
  end

  assign cfg_mulaw = mu_q;
  assign cfg_short = sh_q;

  // R3: configuration frozen outside reset
  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold ##1 !hold) |-> ($stable(cfg_mulaw) && $stable(cfg_short)));

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_pkg::*;
#(
  parameter int WORD_W = LIN_W,
  parameter int CODE_W = MU_W
) (
  input  logic                                clk,
  input  logic                                arst_n,
  input  logic                                sclr,
  input  logic                                cfg_short,
  input  logic                                cfg_mulaw,
  input  logic                                bclk,
  input  logic                                fsync,
  output logic                                tick,
  output logic                                frame_start,
  output logic                                bit_go,
  output logic                                last_bit,
  output logic [$clog2(WORD_W+1)-1:0]         bit_pos
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  frame_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] nbits, bit_idx;
  logic             bclk_q, fsp_q, fsp_d;

  assign tick        = bclk && !bclk_q;
  assign frame_start = tick && fsync && !fsp_q;
  assign nbits       = cfg_mulaw ? CNT_W'(CODE_W) : CNT_W'(WORD_W);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_go = 1'b0;
    fsp_d  = tick ? fsync : fsp_q;
    if (tick) begin
      if (frame_start) begin
        if (cfg_short) begin
          st_d  = FR_ARM;
          cnt_d = '0;
        end else begin
          bit_go = 1'b1;
          st_d   = FR_DATA;
          cnt_d  = CNT_W'(1);
        end
      end else begin
        case (st_q)
          FR_ARM: begin
            bit_go = 1'b1;
            st_d   = FR_DATA;
            cnt_d  = CNT_W'(1);
          end
          FR_DATA: begin
            if (cnt_q == nbits) begin
              st_d = FR_IDLE;
            end else begin
              bit_go = 1'b1;
              cnt_d  = cnt_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bit_idx  = (st_q == FR_DATA && !frame_start) ? cnt_q : '0;
  assign last_bit = bit_go && (bit_idx == nbits - CNT_W'(1));
  assign bit_pos  = nbits - CNT_W'(1) - bit_idx;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      fsp_q  <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (sclr) begin
        st_q  <= FR_IDLE;
        cnt_q <= '0;
        fsp_q <= 1'b0;
      end else begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
        fsp_q <= fsp_d;
      end
    end
  end

  // R4: a data bit never indexes past the word length
  a_r4_bit_in_word: assert property (@(posedge clk) disable iff (!arst_n)
    bit_go |-> (bit_idx < nbits));

  // R5: the short-sync edge carries no data bit
  a_r5_sync_edge_empty: assert property (@(posedge clk) disable iff (!arst_n)
    (frame_start && cfg_short) |-> !bit_go);

endmodule

// File: rtl/pcm_rx_mix.sv
module pcm_rx_mix
  import pcm_pkg::*;
#(
  parameter int WORD_W = LIN_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sclr,
  input  logic              cfg_mulaw,
  input  logic              bit_go,
  input  logic              last_bit,
  input  logic              rx_data,
  input  logic [WORD_W-1:0] int_in,
  output logic [WORD_W-1:0] mix_out,
  output logic              mix_valid
);

  logic [WORD_W-1:0] sh_q, sh_n, sh_d, linear, mix_d;
  logic              val_d;

  assign sh_n   = {sh_q[WORD_W-2:0], rx_data};
  assign linear = cfg_mulaw ? mulaw_decode(sh_n[MU_W-1:0]) : sh_n;

  always_comb begin
    sh_d  = bit_go ? sh_n : sh_q;
    mix_d = mix_out;
    val_d = 1'b0;
    if (last_bit) begin
      mix_d = sat_add(int_in, linear);
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q      <= '0;
      mix_out   <= '0;
      mix_valid <= 1'b0;
    end else if (sclr) begin
      sh_q      <= '0;
      mix_out   <= '0;
      mix_valid <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      mix_out   <= mix_d;
      mix_valid <= val_d;
    end
  end

  // R8: two non-negative operands never produce a negative sum
  a_r8_no_pos_wrap: assert property (@(posedge clk) disable iff (!arst_n)
    (mix_valid && !$past(int_in[WORD_W-1]) && !$past(linear[WORD_W-1]))
      |-> !mix_out[WORD_W-1]);

  // R8: two negative operands never produce a non-negative sum
  a_r8_no_neg_wrap: assert property (@(posedge clk) disable iff (!arst_n)
    (mix_valid && $past(int_in[WORD_W-1]) && $past(linear[WORD_W-1]))
      |-> mix_out[WORD_W-1]);

  // R8: result strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    mix_valid |=> !mix_valid);

endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_pkg::*;
#(
  parameter int WORD_W = LIN_W
) (
  input  logic                          clk,
  input  logic                          arst_n,
  input  logic                          sclr,
  input  logic                          cfg_mulaw,
  input  logic                          tick,
  input  logic                          frame_start,
  input  logic                          bit_go,
  input  logic [$clog2(WORD_W+1)-1:0]   bit_pos,
  input  logic                          tx_en,
  input  logic [WORD_W-1:0]             int_tx,
  output logic                          tx_data,
  output logic                          tx_oe
);

  logic [WORD_W-1:0] word_q, word_d, enc;
  logic              oe_d, dat_d;

  assign enc    = cfg_mulaw ? {{(WORD_W-MU_W){1'b0}}, mulaw_encode(int_tx)} : int_tx;
  assign word_d = frame_start ? enc : word_q;

  always_comb begin
    oe_d  = tx_oe;
    dat_d = tx_data;
    if (tick) begin
      oe_d  = bit_go && tx_en;
      dat_d = bit_go ? word_d[bit_pos] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      word_q  <= '0;
      tx_oe   <= 1'b0;
      tx_data <= 1'b0;
    end else if (sclr) begin
      word_q  <= '0;
      tx_oe   <= 1'b0;
      tx_data <= 1'b0;
    end else begin
      word_q  <= word_d;
      tx_oe   <= oe_d;
      tx_data <= dat_d;
    end
  end

  // R1: reset request silences the lane
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    sclr |=> !tx_oe);

  // R1: driving requires the enable
  a_r1_needs_enable: assert property (@(posedge clk) disable iff (!arst_n)
    tx_oe |-> $past(tx_en));

  // R11: drive state only moves on a bit-clock edge or reset request
  a_r11_oe_on_edge: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(tx_oe) |-> ($past(tick) || $past(sclr)));

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_pkg::*;
#(
  parameter int WORD_W      = LIN_W,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              fmt_pin,
  input  logic              fmt_reg,
  input  logic              sync_sel,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rx_data,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] int_in,
  input  logic [WORD_W-1:0] int_tx,
  output logic [WORD_W-1:0] mix_out,
  output logic              mix_valid,
  output logic              tx_data,
  output logic              tx_oe
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic             arst_n, hold, cfg_mulaw, cfg_short;
  logic             tick, frame_start, bit_go, last_bit;
  logic [CNT_W-1:0] bit_pos;

  pcm_reset_cfg #(.STAGES(RST_STAGES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .fmt_pin   (fmt_pin),
    .fmt_reg   (fmt_reg),
    .sync_sel  (sync_sel),
    .arst_n    (arst_n),
    .hold      (hold),
    .cfg_mulaw (cfg_mulaw),
    .cfg_short (cfg_short)
  );

  pcm_frame_ctl #(.WORD_W(WORD_W), .CODE_W(MU_W)) u_frame (
    .clk         (clk),
    .arst_n      (arst_n),
    .sclr        (hold),
    .cfg_short   (cfg_short),
    .cfg_mulaw   (cfg_mulaw),
    .bclk        (bclk),
    .fsync       (fsync),
    .tick        (tick),
    .frame_start (frame_start),
    .bit_go      (bit_go),
    .last_bit    (last_bit),
    .bit_pos     (bit_pos)
  );

  pcm_rx_mix #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .arst_n    (arst_n),
    .sclr      (hold),
    .cfg_mulaw (cfg_mulaw),
    .bit_go    (bit_go),
    .last_bit  (last_bit),
    .rx_data   (rx_data),
    .int_in    (int_in),
    .mix_out   (mix_out),
    .mix_valid (mix_valid)
  );

  pcm_tx #(.WORD_W(WORD_W)) u_tx (
    .clk         (clk),
    .arst_n      (arst_n),
    .sclr        (hold),
    .cfg_mulaw   (cfg_mulaw),
    .tick        (tick),
    .frame_start (frame_start),
    .bit_go      (bit_go),
    .bit_pos     (bit_pos),
    .tx_en       (tx_en),
    .int_tx      (int_tx),
    .tx_data     (tx_data),
    .tx_oe       (tx_oe)
  );

endmodule

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, fmt_pin, fmt_reg, sync_sel;
  logic        bclk, fsync, rx_data, tx_en;
  logic [15:0] int_in, int_tx, mix_out;
  logic        mix_valid, tx_data, tx_oe;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pcm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fmt_pin(fmt_pin),
    .fmt_reg(fmt_reg), .sync_sel(sync_sel), .bclk(bclk), .fsync(fsync),
    .rx_data(rx_data), .tx_en(tx_en), .int_in(int_in), .int_tx(int_tx),
    .mix_out(mix_out), .mix_valid(mix_valid), .tx_data(tx_data), .tx_oe(tx_oe)
  );

  function automatic int ref_dec(input logic [7:0] code);
    int c, e, m, mag;
    c   = (~code) & 8'hFF;
    e   = (c >> 4) & 7;
    m   = c & 15;
    mag = (((2 * m + 33) << e) * 4) - 132;
    return (c & 128) ? -mag : mag;
  endfunction

  function automatic int ref_enc(input int s);
    int sgn, mag, v, e, m;
    sgn = (s < 0) ? 1 : 0;
    mag = sgn ? -s : s;
    if (mag > 32635) mag = 32635;
    mag = mag + 132;
    v = mag;
    e = 0;
    while (v > 255) begin
      v = v >> 1;
      e++;
    end
    m = (v >> 3) & 15;
    return (~((sgn << 7) | (e << 4) | m)) & 255;
  endfunction

  function automatic int ref_sat(input int a, input int b);
    int s;
    s = a + b;
    if (s > 32767)  return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_edge(input logic fs, input logic d,
                          output logic oe, output logic td,
                          output logic mv, output logic [15:0] mo);
    bclk    = 1'b0;
    fsync   = fs;
    rx_data = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
    oe = tx_oe;
    td = tx_data;
    mv = mix_valid;
    mo = mix_out;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input bit mu, input bit sh, input logic [15:0] rxw,
                           input bit en, input logic [15:0] txv,
                           input logic [15:0] inv, input string tag);
    int          n, expw, exp_mix, rxlin;
    logic        oe, td, mv, idle;
    logic [15:0] mo;
    string       txreq;
    n      = mu ? 8 : 16;
    idle   = mu;
    tx_en  = en;
    int_tx = txv;
    int_in = inv;
    expw   = mu ? ref_enc(int'($signed(txv))) : int'(txv);
    rxlin  = mu ? ref_dec(rxw[7:0]) : int'($signed(rxw));
    exp_mix = ref_sat(int'($signed(inv)), rxlin);
    txreq  = mu ? (sh ? "R5 R9 tx bit" : "R4 R9 tx bit") : (sh ? "R5 tx bit" : "R4 tx bit");
    if (sh) begin
      bit_edge(1'b1, idle, oe, td, mv, mo);
      chk(oe == 1'b0, "R5 sync edge quiet", int'(oe), 0);
    end
    for (int i = 0; i < n; i++) begin
      bit_edge(sh ? 1'b0 : 1'b1, rxw[n-1-i], oe, td, mv, mo);
      chk(oe == en, "R1 drive enable", int'(oe), int'(en));
      if (en) chk(td == ((expw >> (n-1-i)) & 1), txreq, int'(td), (expw >> (n-1-i)) & 1);
    end
    chk(mv == 1'b1, "R8 valid strobe", int'(mv), 1);
    chk(int'($signed(mo)) == exp_mix,
        $sformatf("%s %s mix", tag, mu ? "R6" : "R7"), int'($signed(mo)), exp_mix);
    bit_edge(1'b0, idle, oe, td, mv, mo);
    chk(oe == 1'b0, "R11 release after last bit", int'(oe), 0);
    chk(mv == 1'b0, "R8 strobe single", int'(mv), 0);
  endtask

  task automatic soft_reset();
    @(negedge clk);
    soft_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_oe == 1'b0, "R1 quiet in soft reset", int'(tx_oe), 0);
    soft_rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchecks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  initial begin
    logic        oe, td, mv;
    logic [15:0] mo;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; soft_rst = 1'b0; fmt_pin = 1'b0; fmt_reg = 1'b0; sync_sel = 1'b0;
    bclk = 1'b0; fsync = 1'b0; rx_data = 1'b0; tx_en = 1'b1;
    int_in = '0; int_tx = '0;
    repeat (3) @(negedge clk);
    chk(tx_oe == 1'b0, "R1 reset state oe", int'(tx_oe), 0);
    chk(mix_valid == 1'b0, "R8 reset state valid", int'(mix_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      bit_edge(1'b0, 1'b0, oe, td, mv, mo);
      chk(oe == 1'b0, "R1 initial mode quiet", int'(oe), 0);
    end

    // linear, normal sync
    run_frame(0, 0, 16'h7FFF, 1, 16'hA5C3, 16'h7FFF, "R2 R8 pos");
    run_frame(0, 0, 16'h8000, 1, 16'h0001, 16'h8000, "R8 neg");
    run_frame(0, 0, 16'h0000, 1, 16'h1234, 16'hC350, "R10 idle");
    run_frame(0, 0, 16'h1357, 0, 16'hFFFF, 16'h0100, "R1 disabled");
    for (int k = 0; k < 6; k++)
      run_frame(0, 0, 16'($urandom()), 1, 16'($urandom()), 16'($urandom()), "R7 rand");

    // pin change without reset is ignored
    fmt_pin = 1'b1;
    run_frame(0, 0, 16'h4321, 1, 16'h0F0F, 16'h0011, "R3 held");
    sync_sel = 1'b1;
    run_frame(0, 0, 16'hFEDC, 1, 16'h7000, 16'hFF00, "R3 held");
    sync_sel = 1'b0;

    // mu-law through pin, normal sync
    soft_reset();
    run_frame(1, 0, 16'h00FF, 1, 16'h0000, 16'h1234, "R2 R10 idle");
    run_frame(1, 0, 16'h0000, 1, 16'h8000, 16'h8000, "R8 neg");
    run_frame(1, 0, 16'h0080, 1, 16'h7FFF, 16'h7FFF, "R8 pos");
    for (int k = 0; k < 6; k++)
      run_frame(1, 0, 16'($urandom()) & 16'h00FF, 1, 16'($urandom()), 16'($urandom()), "R6 rand");

    // mu-law through register, short sync, via the reset pin
    fmt_pin = 1'b0; fmt_reg = 1'b1; sync_sel = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_oe == 1'b0, "R1 quiet in pin reset", int'(tx_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_frame(1, 1, 16'h00FF, 1, 16'hFFFF, 16'h0042, "R2 R10 idle");
    for (int k = 0; k < 6; k++)
      run_frame(1, 1, 16'($urandom()) & 16'h00FF, 1, 16'($urandom()), 16'($urandom()), "R6 rand");

    // linear, short sync
    fmt_reg = 1'b0;
    soft_reset();
    run_frame(0, 1, 16'h0000, 1, 16'h8001, 16'hABCD, "R2 R10 idle");
    run_frame(0, 1, 16'h7FFE, 1, 16'h0002, 16'h0005, "R8 pos");
    for (int k = 0; k < 6; k++)
      run_frame(0, 1, 16'($urandom()), 1, 16'($urandom()), 16'($urandom()), "R7 rand");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

endmodule